// File: doc/BRIEF.md
# Credit-Gated Frame Chunk Transmitter

This block sits on the host side of a serial link to a combined MAC and PHY device. It takes an outgoing Ethernet frame as a byte stream and cuts it into fixed-size data chunks. Each chunk goes out as a word stream toward an SPI shift register: one 32-bit header word first, then the payload words. The header tells the far end whether the chunk holds frame data, whether a frame starts in it, and whether and where a frame ends in it.

The far end can only take a limited number of chunks. It reports that number, its transmit credit, in every receive footer. The receive side passes each reported value to this block. The block commits a chunk for sending only while it holds at least one credit, and each committed chunk uses one credit. When the credits run out partway through a frame, the remaining chunks wait for a later credit report.

A chunk is gathered in full before its header is sent, because the header has to say whether the frame ends inside that chunk. The payload length is 32 or 64 bytes, chosen by a configuration input that is held steady between frames.

Top module: `tc_chunk_tx`

## Requirements
- R1: After reset the block is ready for input bytes (`in_ready`=1), presents no output word (`out_valid`=0), and holds zero credits. `in_ready` and `out_valid` are never high together.
- R2: Every header word has bit 31 = 1 (data, not control) and bit 21 = 1 (data valid). Bits 19:16 (start word offset) are 0. All bits not named in R2, R3, R6 and R7 are 0.
- R3: Bit 0 of the header is set so that the 32-bit header holds an odd number of ones.
- R4: After each header come exactly 8 payload words when `cfg_long`=0 (32 bytes) or exactly 16 payload words when `cfg_long`=1 (64 bytes).
- R5: Payload bytes are packed most significant byte first: the first byte of a word is in bits 31:24. Every byte position after the last frame byte of the chunk is zero.
- R6: Header bit 20 (start valid) is 1 only on the first chunk of a frame. A frame always begins at byte 0 of a fresh chunk.
- R7: On the chunk that holds the last byte of a frame, header bit 14 (end valid) is 1 and bits 13:8 hold that byte's index within the payload. On every other chunk, bit 14 and bits 13:8 are 0.
- R8: Each chunk uses one credit when it is committed for sending. With zero credits, a fully gathered chunk waits with `out_valid`=0 and `in_ready`=0 until a credit report arrives.
- R9: A credit report replaces the count. If a report arrives in the same cycle as a chunk is committed, the count becomes the reported value minus one, or 0 when the reported value is 0.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` does not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long | input | 1 | 1 selects 64-byte payloads, 0 selects 32-byte payloads |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| credit_upd | input | 1 | A credit value from a receive footer is present |
| credit_new | input | CW | Credit value reported by the far end |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Header or payload word |
| out_ready | input | 1 | Shift register takes the word this cycle |

## Verification
The header of a chunk appears on the second edge after the chunk's last byte is accepted, provided a credit is held. Each payload word follows on the edge after the previous word is taken. A credit report takes effect on its own edge, so a waiting chunk shows its header one cycle after the report. The bench drives inputs and samples outputs on the falling clock edge. It therefore checks each word in the cycle the word is presented, and the ordered stream of words needs no fixed-latency bookkeeping. For the same-cycle load and commit case, the bench drives the credit report in the exact cycle after a chunk's final byte is accepted. It then checks whether the next chunk sends or stalls, which shows the resulting count at the ports.

// File: rtl/tc_chunk_tx.sv
module tc_chunk_tx #(
  parameter int MAX_WORDS = 16,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_long,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_first,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          credit_upd,
  input  logic [CW-1:0] credit_new,
  output logic          out_valid,
  output logic [31:0]   out_data,
  input  logic          out_ready
);
  localparam int IW = $clog2(MAX_WORDS);
  localparam int BW = $clog2(MAX_WORDS * 4 + 1);
  localparam int EW = 6;

  typedef enum logic [1:0] {S_FILL, S_WAIT, S_HDR, S_PAY} st_t;

  st_t           st_q;
  logic [BW-1:0] bcnt_q;
  logic [IW-1:0] widx_q;
  logic          sv_q, ev_q;
  logic [EW-1:0] ebo_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   mem_q [MAX_WORDS];

  wire take  = in_valid && in_ready;
  wire issue = (st_q == S_WAIT) && (cnt_q != '0);
  wire fire  = out_valid && out_ready;

  wire [BW-1:0] last_byte = cfg_long ? BW'(MAX_WORDS * 4 - 1) : BW'(MAX_WORDS * 2 - 1);
  wire [IW-1:0] last_word = cfg_long ? IW'(MAX_WORDS - 1) : IW'(MAX_WORDS / 2 - 1);
  wire [IW-1:0] wsel      = bcnt_q[IW+1:2];
  wire [1:0]    lane      = bcnt_q[1:0];

  wire [30:0] hdr_hi = {1'b1, 9'b0, 1'b1, sv_q, 4'b0, 1'b0, ev_q, ebo_q, 7'b0};
  wire [31:0] hdr    = {hdr_hi, ~^hdr_hi};
  wire        live   = BW'({widx_q, 2'b00}) < bcnt_q;

  assign in_ready  = (st_q == S_FILL);
  assign out_valid = (st_q == S_HDR) || (st_q == S_PAY);
  assign out_data  = (st_q == S_HDR) ? hdr : (st_q == S_PAY && live) ? mem_q[widx_q] : 32'h0;

  always_ff @(posedge clk) begin
    if (take)
      mem_q[wsel] <= (lane == 2'd0) ? {in_data, 24'h0}
                                    : (mem_q[wsel] | ({in_data, 24'h0} >> (8 * lane)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_FILL;
      bcnt_q <= '0;
      widx_q <= '0;
      sv_q   <= 1'b0;
      ev_q   <= 1'b0;
      ebo_q  <= '0;
    end else begin
      case (st_q)
        S_FILL: if (take) begin
          bcnt_q <= bcnt_q + 1'b1;
          if (in_first) sv_q <= 1'b1;
          if (in_last || bcnt_q == last_byte) begin
            st_q  <= S_WAIT;
            ev_q  <= in_last;
            ebo_q <= in_last ? bcnt_q[EW-1:0] : '0;
          end
        end
        S_WAIT: if (cnt_q != '0) st_q <= S_HDR;
        S_HDR: if (fire) begin
          st_q   <= S_PAY;
          widx_q <= '0;
        end
        default: if (fire) begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == last_word) begin
            st_q   <= S_FILL;
            bcnt_q <= '0;
            sv_q   <= 1'b0;
            ev_q   <= 1'b0;
            ebo_q  <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (credit_upd)
      cnt_q <= issue ? ((credit_new != '0) ? credit_new - 1'b1 : '0) : credit_new;
    else if (issue)
      cnt_q <= cnt_q - 1'b1;
  end

  assert_sides_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hdr_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HDR) |-> (^out_data));

  assert_credit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !credit_upd) |=> (cnt_q == $past(cnt_q) - 1'b1) && (st_q == S_HDR));

  assert_wait_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && cnt_q == '0 && !credit_upd) |=> !out_valid);

  assert_load_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && credit_upd && credit_new != '0) |=> (cnt_q == $past(credit_new) - 1'b1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/tc_chunk_tx_tb.sv
module tc_chunk_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_long = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        credit_upd = 1'b0;
  logic [7:0]  credit_new = 8'h0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tc_chunk_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .credit_upd(credit_upd), .credit_new(credit_new),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // length, cfg_long, seed, backpressure
  localparam int TBL [6][4] = '{
    '{1,   0, 3,  0},
    '{32,  0, 17, 0},
    '{33,  0, 40, 1},
    '{64,  1, 9,  0},
    '{100, 1, 77, 1},
    '{129, 1, 5,  0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkhdr(input bit sv, input bit ev, input int ebo);
    logic [31:0] h;
    h = 32'h8020_0000 | (32'(sv) << 20) | (32'(ev) << 14) | (32'(ebo & 63) << 8);
    h[0] = ~^h[31:1];
    return h;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed + k * 7);
  endfunction

  task automatic run_frame(input int len, input bit lng, input int seed, input int pre,
                           input int hdrld, input int refill, input int exp_st, input bit bp);
    int pw, pb, n, total, bi, got, idle, st, cyc;
    bit prev_hold, arm;
    logic [31:0] prev_data, exp;
    pw = lng ? 16 : 8;
    pb = pw * 4;
    n = (len + pb - 1) / pb;
    total = n * (pw + 1);
    bi = 0; got = 0; idle = 0; st = 0; cyc = 0; prev_hold = 0; arm = 0; prev_data = '0;
    @(negedge clk);
    cfg_long = lng;
    credit_upd = 1'b1;
    credit_new = 8'(pre);
    while (got < total && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      credit_upd = 1'b0;
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last = 1'b0;
      if (arm && hdrld != 0) begin
        credit_upd = 1'b1;
        credit_new = 8'(hdrld);
      end
      arm = 0;
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R10", out_data, prev_data);
      out_ready = bp ? cyc[0] : 1'b1;
      if (out_valid && out_ready) begin
        int c, w;
        c = got / (pw + 1);
        w = got % (pw + 1);
        if (w == 0) begin
          bit ev;
          int ebo;
          ev = (c == n - 1);
          ebo = ev ? (len - 1) % pb : 0;
          exp = mkhdr(c == 0, ev, ebo);
          chk(out_data == exp, "R2", out_data, exp);
          chk(^out_data == 1'b1, "R3", out_data, exp);
          chk(out_data[20] == (c == 0), "R6", out_data, exp);
          chk(out_data[14:8] == exp[14:8], "R7", out_data, exp);
        end else begin
          for (int j = 0; j < 4; j++) begin
            int k;
            k = c * pb + (w - 1) * 4 + j;
            exp[31 - 8*j -: 8] = (k < len) ? pat(seed, k) : 8'h00;
          end
          chk(out_data == exp, "R5", out_data, exp);
        end
        got++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (in_ready && bi < len) begin
        in_valid = 1'b1;
        in_data = pat(seed, bi);
        in_first = (bi == 0);
        in_last = (bi == len - 1);
        if (bi == ((len < pb) ? len : pb) - 1) arm = 1;
        bi++;
      end
      if (!in_ready && !out_valid) idle++; else idle = 0;
      if (idle == 6) begin
        st++;
        idle = 0;
        credit_upd = 1'b1;
        credit_new = 8'(refill);
      end
    end
    chk(got == total, "R4", 32'(got), 32'(total));
    chk(st == exp_st, "R8", 32'(st), 32'(exp_st));
    @(negedge clk);
    in_valid = 1'b0;
    credit_upd = 1'b0;
    out_ready = 1'b1;
    chk(in_ready && !out_valid, "R4", {30'b0, in_ready, out_valid}, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", {30'b0, in_ready, out_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", {30'b0, in_ready, out_valid}, 32'h2);

    // R8: zero credits after reset, a one-chunk frame must stall once
    run_frame(4, 0, 50, 0, 0, 1, 1, 0);

    for (int i = 0; i < 6; i++)
      run_frame(TBL[i][0], TBL[i][1] != 0, TBL[i][2], 200, 0, 0, 0, TBL[i][3] != 0);

    // R8: two-chunk frame with one credit stalls between chunks
    run_frame(40, 0, 11, 1, 0, 1, 1, 0);

    // R9: load of 2 on the commit of chunk 0 leaves 1, so chunk 2 stalls once
    run_frame(96, 0, 23, 1, 2, 1, 1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule